// File: doc/BRIEF.md
# Feature Card Bring-Up Handshake Controller

This block sits on the bus side of one I/O feature card slot. It watches host accesses to the four registers of the slot: board ID, interrupt vector, control and status. It tracks a two-event bring-up handshake. An access to the ID or vector register is the first event. An access to the control register is the second event. A status access clears both. The two events may arrive in either order. When the second distinct event arrives, the block fetches a configuration descriptor from main memory through a single-outstanding memory read port. While that fetch runs, the host port is held off with a busy signal.

Once configured, the same register accesses become job strobes for the downstream card logic. An ID or vector access gives an express-job pulse, and a control access gives a full-job pulse. Reads of the ID and vector registers return the board ID bytes before configuration and the captured interrupt vector afterwards. The captured queue bases, queue depths, vector and queue count are driven out as plain outputs. An empty slot answers no access and raises a bus-timeout indication instead.

Top module: `slot_init_ctrl`

## Requirements
- R1: After reset, host_busy, host_ack, mem_req, mem_fault, bus_timeout, express_go, full_go, cq_seq and all captured configuration outputs are 0.
- R2: Any access, read or write, with host_sel = 3 (status) clears the handshake to nothing seen. A configured slot then returns board ID bytes again.
- R3: host_sel = 0 (ID) and host_sel = 1 (vector) count as event A, and host_sel = 2 (control) counts as event B. A descriptor fetch starts on the access that completes the pair, in either order. Repeating an event already seen starts no fetch.
- R4: Before configuration, a read with host_sel = 0 returns BOARD_ID[15:8] and a read with host_sel = 1 returns BOARD_ID[7:0]. Control and status reads and all writes return 0.
- R5: The fetch issues seven reads, one at a time, each held with a stable address until mem_ack. First comes a word at PTR_LOC, which gives the descriptor base D. Then come words at D and D+4, then bytes at D+8, D+9, D+10 and D+11. mem_size is 2 for a word and 0 for a byte, and byte data is taken from mem_rdata[7:0].
- R6: The seven reads load rq_base (D), cq_base (D+4), rq_depth (D+8), cq_depth (D+9), int_vector (D+10) and rq_count (D+11).
- R7: A read of ID or vector that completes the handshake returns the newly fetched int_vector. After configuration, such reads return int_vector.
- R8: cq_seq is cleared to 0 when a fetch starts. Otherwise it toggles on each cycle cq_post is high.
- R9: When configured, an event-A access gives a one-cycle express_go pulse and an event-B access gives a one-cycle full_go pulse. No strobe is given before configuration or on the access that completes the pair.
- R10: host_busy is high from the cycle after the completing access until the fetch ends. Host requests during that time are ignored. The delayed host_ack comes in the cycle host_busy falls.
- R11: With slot_filled low, an access gives no host_ack. It pulses mem_fault for one cycle, sets bus_timeout until reset, and leaves the handshake unchanged.
- R12: Every accepted access that does not start a fetch is answered with host_ack (and host_rdata) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_filled | input | 1 | High when a card is present in the slot |
| host_req | input | 1 | Host register access, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Register: 0 ID, 1 vector, 2 control, 3 status |
| host_busy | output | 1 | Descriptor fetch in progress; requests ignored |
| host_ack | output | 1 | One-cycle response strobe |
| host_rdata | output | 8 | Read data, valid with host_ack |
| bus_timeout | output | 1 | Sticky: access hit an empty slot |
| mem_fault | output | 1 | One-cycle fault pulse for an empty-slot access |
| mem_req | output | 1 | Memory read request, held until mem_ack |
| mem_addr | output | AW | Memory read address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_ack | input | 1 | Memory read completion |
| mem_rdata | input | 32 | Memory read data, bytes in bits 7:0 |
| cq_post | input | 1 | Downstream posted a completion entry |
| express_go | output | 1 | Express job strobe |
| full_go | output | 1 | Full job strobe |
| rq_base | output | AW | Captured request queue base |
| cq_base | output | AW | Captured completion queue base |
| rq_depth | output | 8 | Captured request queue depth |
| cq_depth | output | 8 | Captured completion queue depth |
| int_vector | output | 8 | Captured interrupt vector |
| rq_count | output | 8 | Captured number of request queues |
| cq_seq | output | 1 | Completion sequence bit |

## Verification
The handshake is driven in both orders. B-then-A is run with repeats of event B beforehand, and A-then-B is run after a status clear with a prior event A. These runs show that only the access completing the pair starts a fetch and that repeats and clears are honoured. The two descriptor sets differ in every field, and byte reads carry non-zero upper lanes, so the second run shows fresh capture and correct lane selection. A status poke is issued while busy, and an access is made to an empty slot. Follow-up reads then show that neither one disturbed the configured state.

// File: rtl/slot_init_pkg.sv
package slot_init_pkg;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned FETCH_STEPS = 7;
  localparam int unsigned STEP_W      = $clog2(FETCH_STEPS);

  typedef logic [STEP_W-1:0] step_t;

  // Offset from the descriptor base for steps 1..6 (step 0 uses the fixed pointer)
  function automatic logic [3:0] step_offset(input step_t s);
    case (s)
      step_t'(1): return 4'd0;
      step_t'(2): return 4'd4;
      step_t'(3): return 4'd8;
      step_t'(4): return 4'd9;
      step_t'(5): return 4'd10;
      step_t'(6): return 4'd11;
      default:    return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] step_size(input step_t s);
    return (s <= step_t'(2)) ? SZ_WORD : SZ_BYTE;
  endfunction

  // Handshake set update: bit0 = event A seen, bit1 = event B seen
  function automatic logic [1:0] hs_merge(input logic [1:0] cur, input logic ev_a,
                                          input logic ev_b, input logic clr);
    return clr ? 2'b00 : (cur | {ev_b, ev_a});
  endfunction

  function automatic logic [7:0] reg_read_value(input logic we, input logic [1:0] sel,
                                                input logic cfg, input logic [15:0] id,
                                                input logic [7:0] vec);
    if (we) return 8'h00;
    if (sel == SEL_ID)  return cfg ? vec : id[15:8];
    if (sel == SEL_VEC) return cfg ? vec : id[7:0];
    return 8'h00;
  endfunction

endpackage

// File: rtl/slot_hs_track.sv
module slot_hs_track
  import slot_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [1:0] acc_sel,
  output logic       cfg_start,
  output logic       job_a,
  output logic       job_b,
  output logic       hs_complete
);

  logic [1:0] hs_q;
  logic [1:0] hs_d;
  logic       ev_a;
  logic       ev_b;
  logic       ev_clr;

  always_comb begin
    ev_a        = acc_valid && (acc_sel == SEL_ID || acc_sel == SEL_VEC);
    ev_b        = acc_valid && (acc_sel == SEL_CTRL);
    ev_clr      = acc_valid && (acc_sel == SEL_STAT);
    hs_complete = (hs_q == 2'b11);
    hs_d        = hs_merge(hs_q, ev_a, ev_b, ev_clr);
    cfg_start   = !hs_complete && (hs_d == 2'b11);
    job_a       = hs_complete && ev_a;
    job_b       = hs_complete && ev_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 2'b00;
    else        hs_q <= hs_d;
  end

  // R3
  start_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> hs_complete);

  // R3
  set_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_complete && !ev_clr |=> hs_complete);

  // R2
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> !hs_complete);

endmodule

// File: rtl/slot_desc_fetch.sv
module slot_desc_fetch
  import slot_init_pkg::*;
#(
  parameter int unsigned   AW      = 32,
  parameter logic [AW-1:0] PTR_LOC = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cq_post,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fetch_done,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [AW-1:0]     rq_base,
  output logic [AW-1:0]     cq_base,
  output logic [7:0]        rq_depth,
  output logic [7:0]        cq_depth,
  output logic [7:0]        int_vector,
  output logic [7:0]        rq_count,
  output logic              cq_seq
);

  localparam step_t LAST_STEP = step_t'(FETCH_STEPS - 1);

  step_t         step_q;
  logic [AW-1:0] base_q;
  logic          xfer;

  always_comb begin
    xfer       = busy && mem_ack;
    fetch_done = xfer && (step_q == LAST_STEP);
    mem_req    = busy;
    mem_addr   = (step_q == step_t'(0)) ? PTR_LOC : base_q + AW'(step_offset(step_q));
    mem_size   = step_size(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      step_q     <= '0;
      base_q     <= '0;
      rq_base    <= '0;
      cq_base    <= '0;
      rq_depth   <= '0;
      cq_depth   <= '0;
      int_vector <= '0;
      rq_count   <= '0;
      cq_seq     <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      step_q <= '0;
      cq_seq <= 1'b0;
    end else begin
      if (cq_post) cq_seq <= ~cq_seq;
      if (xfer) begin
        case (step_q)
          step_t'(0): base_q     <= mem_rdata[AW-1:0];
          step_t'(1): rq_base    <= mem_rdata[AW-1:0];
          step_t'(2): cq_base    <= mem_rdata[AW-1:0];
          step_t'(3): rq_depth   <= mem_rdata[7:0];
          step_t'(4): cq_depth   <= mem_rdata[7:0];
          step_t'(5): int_vector <= mem_rdata[7:0];
          default:    rq_count   <= mem_rdata[7:0];
        endcase
        if (step_q == LAST_STEP) busy   <= 1'b0;
        else                     step_q <= step_q + step_t'(1);
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size));

  // R8
  seq_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !cq_seq);

endmodule

// File: rtl/slot_init_ctrl.sv
module slot_init_ctrl
  import slot_init_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [15:0]   BOARD_ID = 16'h5A3C,
  parameter logic [AW-1:0] PTR_LOC  = AW'(32'h0000_0E00)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_filled,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  output logic          host_busy,
  output logic          host_ack,
  output logic [7:0]    host_rdata,
  output logic          bus_timeout,
  output logic          mem_fault,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          cq_post,
  output logic          express_go,
  output logic          full_go,
  output logic [AW-1:0] rq_base,
  output logic [AW-1:0] cq_base,
  output logic [7:0]    rq_depth,
  output logic [7:0]    cq_depth,
  output logic [7:0]    int_vector,
  output logic [7:0]    rq_count,
  output logic          cq_seq
);

  logic acc_take;
  logic acc_live;
  logic acc_dead;
  logic cfg_start;
  logic job_a;
  logic job_b;
  logic hs_complete;
  logic fetch_done;
  logic trig_rd_q;

  always_comb begin
    acc_take = host_req && !host_busy;
    acc_live = acc_take && slot_filled;
    acc_dead = acc_take && !slot_filled;
  end

  slot_hs_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_live),
    .acc_sel     (host_sel),
    .cfg_start   (cfg_start),
    .job_a       (job_a),
    .job_b       (job_b),
    .hs_complete (hs_complete)
  );

  slot_desc_fetch #(
    .AW      (AW),
    .PTR_LOC (PTR_LOC)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_start),
    .cq_post    (cq_post),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy       (host_busy),
    .fetch_done (fetch_done),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .rq_base    (rq_base),
    .cq_base    (cq_base),
    .rq_depth   (rq_depth),
    .cq_depth   (cq_depth),
    .int_vector (int_vector),
    .rq_count   (rq_count),
    .cq_seq     (cq_seq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack    <= 1'b0;
      host_rdata  <= '0;
      express_go  <= 1'b0;
      full_go     <= 1'b0;
      mem_fault   <= 1'b0;
      bus_timeout <= 1'b0;
      trig_rd_q   <= 1'b0;
    end else begin
      host_ack   <= 1'b0;
      express_go <= 1'b0;
      full_go    <= 1'b0;
      mem_fault  <= 1'b0;
      if (acc_dead) begin
        mem_fault   <= 1'b1;
        bus_timeout <= 1'b1;
      end
      if (acc_live && !cfg_start) begin
        host_ack   <= 1'b1;
        host_rdata <= reg_read_value(host_we, host_sel, hs_complete, BOARD_ID, int_vector);
        express_go <= job_a;
        full_go    <= job_b;
      end
      if (cfg_start)
        trig_rd_q <= !host_we && (host_sel == SEL_ID || host_sel == SEL_VEC);
      if (fetch_done) begin
        host_ack   <= 1'b1;
        host_rdata <= trig_rd_q ? mem_rdata_vec() : 8'h00;
      end
    end
  end

  // At completion the vector was loaded by an earlier step and is stable
  function automatic logic [7:0] mem_rdata_vec();
    return int_vector;
  endfunction

  // R10
  ack_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy) |-> host_ack);

  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> host_busy);

  // R11
  fault_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |-> bus_timeout && !host_ack);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    express_go |-> !full_go && !host_busy);

  // R12
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack && !$past(host_busy) |-> $past(host_req));

endmodule

// File: tb/slot_init_ctrl_test.sv
module slot_init_ctrl_test;

  localparam logic [15:0] BID = 16'h5A3C;
  localparam logic [31:0] PTR = 32'h0000_0E00;
  localparam int MEM_WAIT = 2;

  logic        clk = 0, rst_n = 0, slot_filled = 1;
  logic        host_req = 0, host_we = 0;
  logic [1:0]  host_sel = 0;
  logic        host_busy, host_ack, bus_timeout, mem_fault, mem_req;
  logic [7:0]  host_rdata;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic        cq_post = 0;
  logic        express_go, full_go, cq_seq;
  logic [31:0] rq_base, cq_base;
  logic [7:0]  rq_depth, cq_depth, int_vector, rq_count;

  int n_tests = 0, n_fail = 0, n_exp = 0, n_full = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [31:0] fl_addr[$];
  logic [1:0]  fl_size[$];

  logic [31:0] m_desc, m_rq, m_cq;
  logic [7:0]  m_rqs, m_cqs, m_vec, m_nrq;

  always #10 clk = ~clk;

  slot_init_ctrl uut (
    .clk(clk), .rst_n(rst_n), .slot_filled(slot_filled),
    .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_busy(host_busy), .host_ack(host_ack), .host_rdata(host_rdata),
    .bus_timeout(bus_timeout), .mem_fault(mem_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cq_post(cq_post),
    .express_go(express_go), .full_go(full_go),
    .rq_base(rq_base), .cq_base(cq_base), .rq_depth(rq_depth), .cq_depth(cq_depth),
    .int_vector(int_vector), .rq_count(rq_count), .cq_seq(cq_seq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a == PTR)         return m_desc;
    if (a == m_desc)      return m_rq;
    if (a == m_desc + 4)  return m_cq;
    if (a == m_desc + 8)  return {24'hEEEEEE, m_rqs};
    if (a == m_desc + 9)  return {24'hEEEEEE, m_cqs};
    if (a == m_desc + 10) return {24'hEEEEEE, m_vec};
    if (a == m_desc + 11) return {24'hEEEEEE, m_nrq};
    return 32'hDEAD_BEEF;
  endfunction

  // Memory model: answers each held request after MEM_WAIT cycles
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == MEM_WAIT) begin
          mem_ack = 1;
          mem_rdata = lookup(mem_addr);
          fl_addr.push_back(mem_addr);
          fl_size.push_back(mem_size);
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (host_ack) begin
        if (exp_q.size() == 0) chk("R12 unexpected ack", 1, 0);
        else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
      if (express_go) n_exp++;
      if (full_go) n_full++;
    end
  end

  task automatic acc(input logic [1:0] sel, input logic we, input logic [7:0] exp, input string tag);
    while (host_busy) @(negedge clk);
    host_req = 1; host_sel = sel; host_we = we;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_req = 0;
    chk({tag, " / R12 ack next cycle"}, host_ack, 1);
  endtask

  task automatic trig(input logic [1:0] sel, input logic we, input logic [7:0] exp,
                      input string tag, input bit poke);
    while (host_busy) @(negedge clk);
    host_req = 1; host_sel = sel; host_we = we;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_req = 0;
    chk("R10 busy after completing access", host_busy, 1);
    chk("R10 no early ack", host_ack, 0);
    if (poke) begin
      host_req = 1; host_sel = 2'd3; host_we = 1;
      @(negedge clk);
      host_req = 0;
    end
    while (host_busy) @(negedge clk);
    chk("R7 delayed response delivered", exp_q.size(), 0);
  endtask

  task automatic check_fetch();
    logic [31:0] ea [7];
    logic [1:0]  es [7];
    ea[0] = PTR; ea[1] = m_desc; ea[2] = m_desc + 4; ea[3] = m_desc + 8;
    ea[4] = m_desc + 9; ea[5] = m_desc + 10; ea[6] = m_desc + 11;
    for (int i = 0; i < 7; i++) es[i] = (i < 3) ? 2'd2 : 2'd0;
    chk("R5 read count", fl_addr.size(), 7);
    if (fl_addr.size() == 7) begin
      for (int i = 0; i < 7; i++) begin
        chk("R5 read address", fl_addr[i], ea[i]);
        chk("R5 read size", fl_size[i], es[i]);
      end
    end
    fl_addr.delete(); fl_size.delete();
    chk("R6 rq_base", rq_base, m_rq);
    chk("R6 cq_base", cq_base, m_cq);
    chk("R6 rq_depth", rq_depth, m_rqs);
    chk("R6 cq_depth", cq_depth, m_cqs);
    chk("R6 int_vector", int_vector, m_vec);
    chk("R6 rq_count", rq_count, m_nrq);
  endtask

  task automatic pulse_post();
    cq_post = 1;
    @(negedge clk);
    cq_post = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_desc = 32'h0000_2000; m_rq = 32'h0001_0040; m_cq = 32'h0001_0800;
    m_rqs = 8'h10; m_cqs = 8'h08; m_vec = 8'hA5; m_nrq = 8'h03;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_busy", host_busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 host_ack", host_ack, 0);
    chk("R1 bus_timeout", bus_timeout, 0);
    chk("R1 mem_fault", mem_fault, 0);
    chk("R1 strobes", {express_go, full_go}, 0);
    chk("R1 captured", {rq_base, cq_base, rq_depth, cq_depth, int_vector, rq_count, cq_seq}, 0);

    // Pre-configuration reads and repeats (B then A order)
    acc(2'd0, 0, BID[15:8], "R4 id high byte");
    acc(2'd1, 0, BID[7:0],  "R4 vec low byte");
    chk("R3 repeated event A no fetch", fl_addr.size(), 0);
    acc(2'd3, 1, 8'h00, "R2 status write");
    acc(2'd2, 0, 8'h00, "R4 control read zero");
    chk("R2 clear prevented fetch", fl_addr.size(), 0);
    acc(2'd2, 1, 8'h00, "R4 control write zero");
    chk("R3 repeated event B no fetch", fl_addr.size(), 0);
    trig(2'd0, 0, 8'hA5, "R7 completing id read returns vector", 0);
    check_fetch();
    chk("R8 seq clear after config", cq_seq, 0);
    chk("R9 no strobe before config", n_exp + n_full, 0);

    // Configured: job strobes
    acc(2'd0, 1, 8'h00, "R9 express write");
    chk("R9 express count", n_exp, 1);
    chk("R9 full count", n_full, 0);
    acc(2'd2, 0, 8'h00, "R9 full read");
    chk("R9 full count after ctrl", n_full, 1);
    acc(2'd1, 0, 8'hA5, "R7 configured vec read");
    chk("R9 express count after vec", n_exp, 2);

    // Sequence bit and re-configuration in A then B order
    pulse_post();
    chk("R8 toggle on post", cq_seq, 1);
    acc(2'd3, 0, 8'h00, "R2 status read");
    acc(2'd1, 0, BID[7:0], "R2 cleared slot shows board id");
    m_desc = 32'h0000_3100; m_rq = 32'h0002_0000; m_cq = 32'h0002_4000;
    m_rqs = 8'h04; m_cqs = 8'h06; m_vec = 8'h6E; m_nrq = 8'h01;
    trig(2'd2, 1, 8'h00, "R3 A then B completing write", 1);
    check_fetch();
    chk("R8 seq cleared by reconfig", cq_seq, 0);
    chk("R9 no strobe on completing access", n_exp * 16 + n_full, 2 * 16 + 1);
    acc(2'd0, 0, 8'h6E, "R10 poke while busy ignored");

    // Empty slot
    slot_filled = 0;
    host_req = 1; host_sel = 2'd0; host_we = 0;
    @(negedge clk);
    host_req = 0;
    chk("R11 fault pulse", mem_fault, 1);
    chk("R11 no ack", host_ack, 0);
    chk("R11 timeout set", bus_timeout, 1);
    @(negedge clk);
    chk("R11 fault one cycle", mem_fault, 0);
    chk("R11 timeout sticky", bus_timeout, 1);
    slot_filled = 1;
    acc(2'd1, 0, 8'h6E, "R11 handshake untouched");

    repeat (4) @(negedge clk);
    chk("R12 all responses seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule